// File: doc/BRIEF.md
# DMA Completion Interrupt Aggregator

This block gathers completion events from a set of DMA channel engines into one level-sensitive interrupt line. Each channel drives a single-cycle completion pulse on its own input bit. The block latches that pulse into a raw status bit at the same index. An enable mask selects which latched bits are allowed to raise the interrupt. Software sees the raw status, the masked pending view and the enable mask through a 32-bit register port. It acknowledges a completion by writing a one to the matching status bit.

A mask of zero silences every channel, but completions keep latching underneath it. When the mask is opened again, any event that arrived in the meantime raises the interrupt at once. The register port also holds an addressing-mode control bit, which is driven out to the channel engines. Channel count is a parameter of up to 32.

Register map, as byte offsets on the port:

| Offset | Register | Access |
|---|---|---|
| 0x000034 | addressing-mode control | bit 0 read/write |
| 0x080000 | raw completion status | write one to clear |
| 0x080004 | pending (status AND enable) | read-only |
| 0x080008 | interrupt enable mask | read/write |

Top module: `dma_irq_aggregator`

## Requirements
- R1: After reset every register reads 0, `irq` is low, `addr32_mode` is low and `bus_rvalid` is low.
- R2: A one-cycle pulse on `done_pulse[n]` sets status bit n (offset 0x080000) from the next cycle on, and it sets no other bit.
- R3: A write to offset 0x080000 clears each status bit whose write-data bit is 1, and it leaves bits written 0 unchanged. Writing 0xFFFFFFFF clears all bits.
- R4: When a completion pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: A read of offset 0x080004 returns raw status AND enable mask.
- R6: `irq` is high exactly while status AND enable is non-zero. It is combinational from the registers, so it follows a status or enable change in the same cycle that change becomes visible.
- R7: With the enable mask at 0, pulses still latch into status and `irq` stays low. Writing the mask later raises `irq` for bits that latched earlier.
- R8: Writes to offset 0x080004 change neither status nor the enable mask.
- R9: A write to offset 0x000034 stores write-data bit 0 and drives it on `addr32_mode`. A read of that offset returns the stored bit in bit 0 and zeros in bits 31:1.
- R10: A read of any offset other than the four mapped ones returns 0 and changes no register.
- R11: A read request (`bus_sel`=1, `bus_we`=0) yields `bus_rvalid`=1 with its data on `bus_rdata` exactly one cycle later. `bus_rvalid` is 0 in every other cycle.
- R12: The enable mask at offset 0x080008 stores write-data bits NCH-1:0. In status, pending and enable reads, bits NCH and above read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| done_pulse | input | NCH | One-cycle completion pulse per channel |
| bus_sel | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data strobe, one cycle after a read request |
| irq | output | 1 | Level interrupt, high while any enabled status bit is set |
| addr32_mode | output | 1 | Addressing-mode bit for the channel engines |

## Verification
The assertions assume that each access lasts exactly one cycle with known address and data. They also assume that completion pulses are known values, with no constraint on how many channels fire together. The bench meets this by driving every access and pulse on the falling edge for exactly one cycle. It sweeps every channel index, a grid of status patterns against all 256 enable masks, and the collision of a clear with a new pulse. It deliberately writes the read-only and mode offsets with all-ones data.

// File: rtl/dirq_pkg.sv
// Package: shared register offsets and the decoded register selector.
// Assumes offsets are byte addresses compared at full 32-bit width.
package dirq_pkg;

    localparam logic [31:0] OFS_MODE    = 32'h0000_0034;
    localparam logic [31:0] OFS_STATUS  = 32'h0008_0000;
    localparam logic [31:0] OFS_PENDING = 32'h0008_0004;
    localparam logic [31:0] OFS_ENABLE  = 32'h0008_0008;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_STATUS,
        SEL_PENDING,
        SEL_ENABLE
    } reg_sel_e;

    // Map a zero-extended byte offset onto the register it names.
    function automatic reg_sel_e decode_offset(input logic [31:0] ofs);
        reg_sel_e sel;
        case (ofs)
            OFS_MODE:    sel = SEL_MODE;
            OFS_STATUS:  sel = SEL_STATUS;
            OFS_PENDING: sel = SEL_PENDING;
            OFS_ENABLE:  sel = SEL_ENABLE;
            default:     sel = SEL_NONE;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/dirq_regif.sv
// Module: dirq_regif
// Decodes single-cycle register accesses into write strobes for the
// status and enable banks, holds the addressing-mode bit, and returns
// registered read data one cycle after each read request.
// Assumes: ADDR_W <= 32 and ADDR_W >= 20; NCH in 1..32.
module dirq_regif #(
    parameter int NCH    = 8,
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [NCH-1:0]    status_i,
    input  logic [NCH-1:0]    pending_i,
    input  logic [NCH-1:0]    enable_i,
    output logic              clr_we_o,
    output logic [NCH-1:0]    clr_mask_o,
    output logic              en_we_o,
    output logic [NCH-1:0]    en_wdata_o,
    output logic              mode_o,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid
);
    import dirq_pkg::*;

    logic [31:0] addr_ext;
    reg_sel_e    sel;
    logic        rd_req;
    logic        wr_req;
    logic        mode_q;
    logic [31:0] rd_mux;
    logic        unused_wbits;

    // Zero-extend the offset and name the register it selects.
    always_comb begin
        addr_ext = '0;
        addr_ext[ADDR_W-1:0] = bus_addr;
        sel = decode_offset(addr_ext);
    end

    assign rd_req = bus_sel && !bus_we;
    assign wr_req = bus_sel && bus_we;

    assign clr_we_o     = wr_req && (sel == SEL_STATUS);
    assign en_we_o      = wr_req && (sel == SEL_ENABLE);
    assign clr_mask_o   = bus_wdata[NCH-1:0];
    assign en_wdata_o   = bus_wdata[NCH-1:0];
    assign unused_wbits = ^bus_wdata;

    // Store bit 0 of writes to the addressing-mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= 1'b0;
        else if (wr_req && (sel == SEL_MODE))
            mode_q <= bus_wdata[0];
    end

    assign mode_o = mode_q;

    // Select read data, padding channel vectors with zeros above NCH.
    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_MODE:    rd_mux[0]       = mode_q;
            SEL_STATUS:  rd_mux[NCH-1:0] = status_i;
            SEL_PENDING: rd_mux[NCH-1:0] = pending_i;
            SEL_ENABLE:  rd_mux[NCH-1:0] = enable_i;
            default:     rd_mux          = '0;
        endcase
    end

    // Register read data and its strobe for the cycle after a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= rd_req;
            bus_rdata  <= rd_req ? rd_mux : '0;
        end
    end

    p_rvalid_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid);
    p_rvalid_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !bus_rvalid);
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && sel == SEL_NONE) |=> (bus_rdata == 32'h0));
    p_mode_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && sel == SEL_MODE) |=> (mode_o == $past(bus_wdata[0])));

endmodule

// File: rtl/dirq_status_bank.sv
// Module: dirq_status_bank
// One latch per channel: a completion pulse sets it, a write-one clears
// it, and a pulse in the same cycle as a clear keeps the bit set.
// Assumes: done_i bits are single-cycle pulses from the channel engines.
module dirq_status_bank #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] done_i,
    input  logic           clr_we_i,
    input  logic [NCH-1:0] clr_mask_i,
    output logic [NCH-1:0] status_o
);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_bit
        // Set on completion, else clear on a write-one to this bit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                status_o[ch] <= 1'b0;
            else if (done_i[ch])
                status_o[ch] <= 1'b1;
            else if (clr_we_i && clr_mask_i[ch])
                status_o[ch] <= 1'b0;
        end

        p_pulse_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
            done_i[ch] |=> status_o[ch]);
        p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we_i && clr_mask_i[ch] && !done_i[ch]) |=> !status_o[ch]);
        p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!done_i[ch] && !(clr_we_i && clr_mask_i[ch])) |=> $stable(status_o[ch]));
    end

endmodule

// File: rtl/dirq_mask_irq.sv
// Module: dirq_mask_irq
// Holds the enable mask, forms pending = status AND enable, and raises
// the interrupt line while any pending bit is set.
// Assumes: status_i comes from flops, so irq_o is glitch-free per cycle.
module dirq_mask_irq #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] status_i,
    input  logic           en_we_i,
    input  logic [NCH-1:0] en_wdata_i,
    output logic [NCH-1:0] enable_o,
    output logic [NCH-1:0] pending_o,
    output logic           irq_o
);

    // Load the enable mask on a write to its offset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable_o <= '0;
        else if (en_we_i)
            enable_o <= en_wdata_i;
    end

    assign pending_o = status_i & enable_o;
    assign irq_o     = |pending_o;

    p_mask_silences_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_o == '0) |-> !irq_o);
    p_irq_needs_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status_i != '0));
    p_enable_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
        en_we_i |=> (enable_o == $past(en_wdata_i)));

endmodule

// File: rtl/dma_irq_aggregator.sv
// Module: dma_irq_aggregator (top)
// Collects per-channel completion pulses into a write-one-to-clear
// status register, masks them with an enable register and drives one
// level interrupt. Also exports an addressing-mode control bit.
// Assumes: one-cycle register accesses; NCH in 1..32; ADDR_W in 20..32.
module dma_irq_aggregator #(
    parameter int NCH    = 8,
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    done_pulse,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              irq,
    output logic              addr32_mode
);
    import dirq_pkg::*;

    logic           clr_we;
    logic [NCH-1:0] clr_mask;
    logic           en_we;
    logic [NCH-1:0] en_wdata;
    logic [NCH-1:0] status;
    logic [NCH-1:0] enable;
    logic [NCH-1:0] pending;
    logic [31:0]    addr_ext;

    dirq_regif #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .status_i   (status),
        .pending_i  (pending),
        .enable_i   (enable),
        .clr_we_o   (clr_we),
        .clr_mask_o (clr_mask),
        .en_we_o    (en_we),
        .en_wdata_o (en_wdata),
        .mode_o     (addr32_mode),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    dirq_status_bank #(.NCH(NCH)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_i     (done_pulse),
        .clr_we_i   (clr_we),
        .clr_mask_i (clr_mask),
        .status_o   (status)
    );

    dirq_mask_irq #(.NCH(NCH)) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .status_i   (status),
        .en_we_i    (en_we),
        .en_wdata_i (en_wdata),
        .enable_o   (enable),
        .pending_o  (pending),
        .irq_o      (irq)
    );

    // Zero-extended offset, used only by the top-level checks.
    always_comb begin
        addr_ext = '0;
        addr_ext[ADDR_W-1:0] = bus_addr;
    end

    p_pending_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && addr_ext == OFS_PENDING && done_pulse == '0)
        |=> ($stable(status) && $stable(enable)));
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!irq && !addr32_mode && !bus_rvalid));

endmodule

// File: tb/test_dma_irq_aggregator.sv
// Bench: sweeps channels, status/enable grids and corner cases with an
// arithmetic reference model of the register file.
module test_dma_irq_aggregator;
    localparam int NCH    = 8;
    localparam int ADDR_W = 20;
    localparam logic [31:0] A_MODE = 32'h34;
    localparam logic [31:0] A_STAT = 32'h80000;
    localparam logic [31:0] A_PEND = 32'h80004;
    localparam logic [31:0] A_EN   = 32'h80008;
    localparam logic [31:0] CHMASK = 32'h0000_00FF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    done_pulse = '0;
    logic              bus_sel = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic              irq;
    logic              addr32_mode;

    int          n_checks = 0;
    int          n_errors = 0;
    bit          finished = 1'b0;
    logic [31:0] m_stat = '0;
    logic [31:0] m_en   = '0;
    logic [31:0] rd;

    always #5 clk = ~clk;

    dma_irq_aggregator #(.NCH(NCH), .ADDR_W(ADDR_W)) i_dma_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .done_pulse(done_pulse),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .irq(irq), .addr32_mode(addr32_mode)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a[ADDR_W-1:0]; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rdreg(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a[ADDR_W-1:0];
        @(negedge clk);
        bus_sel = 1'b0;
        chk("R11 rvalid", {31'b0, bus_rvalid}, 32'h1);
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [NCH-1:0] v);
        @(negedge clk);
        done_pulse = v;
        @(negedge clk);
        done_pulse = '0;
        m_stat = m_stat | {24'b0, v};
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 mode", {31'b0, addr32_mode}, 32'h0);
        chk("R1 rvalid", {31'b0, bus_rvalid}, 32'h0);
        rdreg(A_STAT, rd); chk("R1 status", rd, 32'h0);
        rdreg(A_PEND, rd); chk("R1 pending", rd, 32'h0);
        rdreg(A_EN, rd);   chk("R1 enable", rd, 32'h0);
        rdreg(A_MODE, rd); chk("R1 mode read", rd, 32'h0);
        @(negedge clk);
        chk("R11 rvalid drops", {31'b0, bus_rvalid}, 32'h0);

        // R2 / R7: each channel latches its own bit only, irq masked.
        for (int n = 0; n < NCH; n++) begin
            pulse(NCH'(1) << n);
            chk("R7 irq masked", {31'b0, irq}, 32'h0);
            rdreg(A_STAT, rd); chk("R2 single bit", rd, 32'h1 << n);
            wr(A_STAT, 32'h1 << n); m_stat = '0;
            rdreg(A_STAT, rd); chk("R3 bit cleared", rd, 32'h0);
        end

        // R3: partial clear, zero write leaves bits, all-ones clears all.
        pulse(8'hFF);
        wr(A_STAT, 32'h0000_000F);
        rdreg(A_STAT, rd); chk("R3 partial", rd, 32'h0000_00F0);
        wr(A_STAT, 32'h0);
        rdreg(A_STAT, rd); chk("R3 zero write", rd, 32'h0000_00F0);
        wr(A_STAT, 32'hFFFF_FFFF);
        rdreg(A_STAT, rd); chk("R3 all clear", rd, 32'h0);

        // R4: pulse and clear on the same bit in the same cycle.
        pulse(8'h08);
        @(negedge clk);
        done_pulse = 8'h08; bus_sel = 1'b1; bus_we = 1'b1;
        bus_addr = A_STAT[ADDR_W-1:0]; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        done_pulse = '0; bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
        rdreg(A_STAT, rd); chk("R4 new pulse wins", rd, 32'h08);
        wr(A_STAT, 32'hFFFF_FFFF);

        // R7: latched while masked, exposed when enabled.
        wr(A_EN, 32'h0);
        pulse(8'h03);
        chk("R7 masked irq", {31'b0, irq}, 32'h0);
        rdreg(A_STAT, rd); chk("R7 latched", rd, 32'h03);
        wr(A_EN, 32'h02);
        chk("R7 irq after enable", {31'b0, irq}, 32'h1);
        rdreg(A_PEND, rd); chk("R7 pending", rd, 32'h02);
        wr(A_STAT, 32'h02);
        chk("R6 irq drops on clear", {31'b0, irq}, 32'h0);
        wr(A_STAT, 32'hFFFF_FFFF);

        // R8: pending is read-only.
        pulse(8'h05);
        wr(A_EN, 32'hFF);
        wr(A_PEND, 32'hFFFF_FFFF);
        rdreg(A_STAT, rd); chk("R8 status kept", rd, 32'h05);
        rdreg(A_EN, rd);   chk("R8 enable kept", rd, 32'hFF);
        wr(A_PEND, 32'h0);
        rdreg(A_PEND, rd); chk("R8 pending kept", rd, 32'h05);

        // R12: enable stores only NCH bits.
        wr(A_EN, 32'hFFFF_FFFF);
        rdreg(A_EN, rd); chk("R12 enable width", rd, CHMASK);

        // R10: unmapped reads return zero and change nothing.
        rdreg(32'h0008_0010, rd); chk("R10 unmapped hi", rd, 32'h0);
        rdreg(32'h0000_0000, rd); chk("R10 unmapped lo", rd, 32'h0);
        rdreg(32'h0000_0030, rd); chk("R10 unmapped near", rd, 32'h0);
        rdreg(A_STAT, rd); chk("R10 status untouched", rd, 32'h05);
        rdreg(A_EN, rd);   chk("R10 enable untouched", rd, CHMASK);
        wr(A_STAT, 32'hFFFF_FFFF); m_stat = '0;

        // R9: addressing-mode bit.
        wr(A_MODE, 32'hFFFF_FFFF);
        chk("R9 mode set", {31'b0, addr32_mode}, 32'h1);
        rdreg(A_MODE, rd); chk("R9 mode read", rd, 32'h1);
        wr(A_MODE, 32'hFFFF_FFFE);
        chk("R9 mode clear", {31'b0, addr32_mode}, 32'h0);

        // R5 / R6: status grid against every enable mask.
        for (int s = 0; s < 256; s += 17) begin
            for (int e = 0; e < 256; e++) begin
                m_stat = '0;
                pulse(8'(s));
                wr(A_EN, 32'(e)); m_en = 32'(e);
                chk("R6 irq", {31'b0, irq}, {31'b0, ((m_stat & m_en) != 0)});
                rdreg(A_PEND, rd); chk("R5 pending", rd, m_stat & m_en);
                wr(A_STAT, 32'hFFFF_FFFF);
                chk("R6 irq after clear", {31'b0, irq}, 32'h0);
            end
        end

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule